// File: doc/BRIEF.md
# Process-Tag TLB Sweep Engine

This engine walks every entry of a two-sided translation buffer (an instruction side and a data side, each with 4 ways of 16 sets) and reports each page that belongs to a given process tag. A one-cycle `start_i` pulse loads a process tag. The engine then reads all 128 entries, one per cycle, through a synchronous read port that has one cycle of latency. An entry qualifies when it is valid, is not global, and carries the requested tag. For each qualifying entry the engine presents a flush request that carries the page's virtual base address, rebuilt from the entry's page-number field. It holds that request on a valid/ready handshake and pauses the walk until the request is taken. `done_o` pulses for one cycle when the walk is finished.

The engine does not change the entries. A downstream translation cache consumes the flush requests. Issuing a read is overlapped with comparing the previous read's data, so when nothing matches the walk takes one cycle per entry plus one cycle to drain.

The control is a four-state machine:
- IDLE: waits for a start pulse; the *launch* transition goes to SCAN.
- SCAN: issues reads and compares returned data. On a match, the *catch* transition goes to HOLD. When the last entry compares without a match, the *finish* transition goes to DONE.
- HOLD: presents the request. When the request is accepted, *resume* returns to SCAN, or *finish* goes to DONE if the matched entry was the last one.
- DONE: lasts one cycle, then *retire* returns to IDLE.

Top module: `tlb_pid_sweep`

## Requirements
- R1: After reset the engine is idle. `busy_o`, `rd_en_o`, `flush_valid_o` and `done_o` are all 0, and they stay 0 until a start pulse arrives.
- R2: Only bits 7:0 of `pid_i` take part in the comparison; bits 15:8 are ignored.
- R3: A walk issues exactly 128 reads, each entry once, in this order: side 0 then side 1; within a side, way 0 to 3; within a way, set 0 to 15. The entry number {side, way, set} counts up from 0 to 127.
- R4: An entry qualifies only when low-word bit 3 (valid) is 1, low-word bit 4 (global) is 0, and high-word bits 7:0 equal the requested tag.
- R5: The flush address is high-word bits 31:13 placed at address bits 31:13, with address bits 12:0 equal to zero.
- R6: Read data is expected one cycle after `rd_en_o`. With no pending request the engine issues one read per cycle. For a walk with no match, `done_o` is high after the 130th rising edge, counting the edge that samples the start pulse as the first.
- R7: While `flush_valid_o` is high and `flush_ready_i` is low, the request and its address do not change. No read is issued while a request is pending.
- R8: A start pulse that arrives while `busy_o` is high is ignored, including its tag value. The walk in progress continues unchanged.
- R9: `done_o` is high for exactly one cycle. It comes after the last entry is compared and after the last request is accepted. The engine is idle in the following cycle.
- R10: Flush requests appear in walk order, one per qualifying entry, and no others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk; ignored unless idle |
| pid_i | input | 16 | Requested process tag; only bits 7:0 used |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| rd_en_o | output | 1 | Read strobe to the entry store |
| rd_side_o | output | 1 | Side being read (0 instruction, 1 data) |
| rd_way_o | output | 2 | Way being read |
| rd_idx_o | output | 4 | Set index being read |
| rd_hi_i | input | 32 | High word returned one cycle after the read strobe |
| rd_lo_i | input | 32 | Low word returned one cycle after the read strobe |
| flush_valid_o | output | 1 | Flush request pending |
| flush_ready_i | input | 1 | Consumer accepts the request |
| flush_addr_o | output | 32 | Virtual page base address to flush |

## Verification
The walk is tried with five kinds of store content and consumer behaviour:
- A store where no entry matches. This measures the steady one-read-per-cycle pace and the drain cycle.
- A mixed store with valid, invalid and global entries, and with tags that match only in the upper byte. This separates the three qualifying conditions from each other and checks that the upper tag bits are masked.
- The same kind of content with random backpressure. This exposes any request that changes or any read that slips out while a request is held.
- A store with matches on the first entry, on back-to-back entries and on the very last entry, together with long stalls. This covers the restart after a stall and the end-of-walk condition that goes through HOLD.
- A walk during which a second start pulse with a different tag arrives. This shows whether that pulse reaches the comparison.

// File: rtl/tlbsw_pkg.sv
package tlbsw_pkg;

    // Entry word field positions decoded by the matcher.
    localparam int ENT_VALID_BIT  = 3;
    localparam int ENT_GLOBAL_BIT = 4;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_SCAN = 2'd1,
        SW_HOLD = 2'd2,
        SW_DONE = 2'd3
    } sw_state_e;

endpackage

// File: rtl/tlbsw_walker.sv
module tlbsw_walker #(
    parameter int SIDES = 2,
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    localparam int ENTRIES = SIDES * WAYS * SETS,
    localparam int SIDE_W  = (SIDES > 1) ? $clog2(SIDES) : 1,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int IDX_W   = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic              all_issued_o,
    output logic              last_o,
    output logic [SIDE_W-1:0] side_o,
    output logic [WAY_W-1:0]  way_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int PTR_W = $clog2(ENTRIES + 1);
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(ENTRIES);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    logic [PTR_W-1:0] ptr_q;

    // Set index is the fastest-moving field, side the slowest.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clear_i) begin
            ptr_q <= '0;
        end else if (step_i && (ptr_q != PTR_END)) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    always_comb begin
        all_issued_o = (ptr_q == PTR_END);
        last_o       = (ptr_q == PTR_LAST);
        idx_o        = IDX_W'(ptr_q % PTR_W'(SETS));
        way_o        = WAY_W'((ptr_q / PTR_W'(SETS)) % PTR_W'(WAYS));
        side_o       = SIDE_W'(ptr_q / PTR_W'(SETS * WAYS));
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_END);                                               // R3

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && !all_issued_o) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R3

endmodule

// File: rtl/tlbsw_match.sv
module tlbsw_match
    import tlbsw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PID_W      = 8,
    parameter int PAGE_SHIFT = 13
) (
    input  logic [ADDR_W-1:0] hi_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] vaddr_o
);
    logic tag_eq;
    logic live;

    always_comb begin
        tag_eq  = (hi_i[PID_W-1:0] == pid_i);
        live    = lo_i[ENT_VALID_BIT] & ~lo_i[ENT_GLOBAL_BIT];
        hit_o   = live & tag_eq;
        vaddr_o = {hi_i[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/tlb_pid_sweep.sv
module tlb_pid_sweep
    import tlbsw_pkg::*;
#(
    parameter int SIDES      = 2,
    parameter int WAYS       = 4,
    parameter int SETS       = 16,
    parameter int ADDR_W     = 32,
    parameter int PID_W      = 8,
    parameter int REQ_W      = 16,
    parameter int PAGE_SHIFT = 13,
    localparam int SIDE_W    = (SIDES > 1) ? $clog2(SIDES) : 1,
    localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int IDX_W     = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REQ_W-1:0]  pid_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_en_o,
    output logic [SIDE_W-1:0] rd_side_o,
    output logic [WAY_W-1:0]  rd_way_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    input  logic [ADDR_W-1:0] rd_hi_i,
    input  logic [ADDR_W-1:0] rd_lo_i,
    output logic              flush_valid_o,
    input  logic              flush_ready_i,
    output logic [ADDR_W-1:0] flush_addr_o
);
    sw_state_e         state_q, state_d;
    logic [PID_W-1:0]  pid_q;
    logic              cmp_v_q, cmp_last_q;
    logic              hold_last_q;
    logic [ADDR_W-1:0] hold_addr_q;

    logic              launch;
    logic              all_issued, at_last;
    logic              hit;
    logic [ADDR_W-1:0] hit_addr;
    logic              catch_now;

    tlbsw_walker #(.SIDES(SIDES), .WAYS(WAYS), .SETS(SETS)) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (launch),
        .step_i       (rd_en_o),
        .all_issued_o (all_issued),
        .last_o       (at_last),
        .side_o       (rd_side_o),
        .way_o        (rd_way_o),
        .idx_o        (rd_idx_o)
    );

    tlbsw_match #(.ADDR_W(ADDR_W), .PID_W(PID_W), .PAGE_SHIFT(PAGE_SHIFT)) u_match (
        .hi_i    (rd_hi_i),
        .lo_i    (rd_lo_i),
        .pid_i   (pid_q),
        .hit_o   (hit),
        .vaddr_o (hit_addr)
    );

    always_comb begin
        launch    = (state_q == SW_IDLE) && start_i;
        catch_now = (state_q == SW_SCAN) && cmp_v_q && hit;
        // A match in the compare stage withholds the next read.
        rd_en_o   = (state_q == SW_SCAN) && !all_issued && !catch_now;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: if (start_i) state_d = SW_SCAN;
            SW_SCAN: begin
                if (catch_now)                  state_d = SW_HOLD;
                else if (cmp_v_q && cmp_last_q) state_d = SW_DONE;
            end
            SW_HOLD: if (flush_ready_i) state_d = hold_last_q ? SW_DONE : SW_SCAN;
            SW_DONE: state_d = SW_IDLE;
            default: state_d = SW_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q       <= '0;
            cmp_v_q     <= 1'b0;
            cmp_last_q  <= 1'b0;
            hold_last_q <= 1'b0;
            hold_addr_q <= '0;
        end else begin
            if (launch) pid_q <= pid_i[PID_W-1:0];
            cmp_v_q    <= rd_en_o;
            cmp_last_q <= rd_en_o && at_last;
            if (catch_now) begin
                hold_addr_q <= hit_addr;
                hold_last_q <= cmp_last_q;
            end
        end
    end

    // Output decode
    always_comb begin
        busy_o        = (state_q != SW_IDLE);
        done_o        = (state_q == SW_DONE);
        flush_valid_o = (state_q == SW_HOLD);
        flush_addr_o  = hold_addr_q;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rd_en_o && !flush_valid_o && !done_o));            // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid_o && !flush_ready_i) |=> (flush_valid_o && $stable(flush_addr_o))); // R7

    AST_NO_READ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid_o |-> !rd_en_o);                                     // R7

    AST_TAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(pid_q));                         // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));                                // R9

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid_o |-> (flush_addr_o[PAGE_SHIFT-1:0] == '0));         // R5

endmodule

// File: tb/test_tlb_pid_sweep.sv
module test_tlb_pid_sweep;
    localparam int N = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pid = '0;
    logic        busy, done, rd_en, fvalid, fready;
    logic [0:0]  rd_side;
    logic [1:0]  rd_way;
    logic [3:0]  rd_idx;
    logic [31:0] rd_hi = '0, rd_lo = '0, faddr;

    logic [31:0] mem_hi [N];
    logic [31:0] mem_lo [N];

    int checks = 0, fails = 0, cyc = 0;
    int bp_mode = 0, bp_cnt = 0;
    int exp_rd = 0;
    logic [31:0] expq [$];
    bit   prev_v = 0, prev_r = 0, prev_done = 0;
    logic [31:0] prev_a = '0;

    always #5 clk = ~clk;

    tlb_pid_sweep i_tlb_pid_sweep (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pid_i(pid),
        .busy_o(busy), .done_o(done), .rd_en_o(rd_en),
        .rd_side_o(rd_side), .rd_way_o(rd_way), .rd_idx_o(rd_idx),
        .rd_hi_i(rd_hi), .rd_lo_i(rd_lo),
        .flush_valid_o(fvalid), .flush_ready_i(fready), .flush_addr_o(faddr)
    );

    // Entry store with one cycle of read latency
    always @(posedge clk) if (rd_en) begin
        rd_hi <= mem_hi[{rd_side, rd_way, rd_idx}];
        rd_lo <= mem_lo[{rd_side, rd_way, rd_idx}];
    end

    // Consumer ready pattern
    always @(posedge clk) begin
        #1;
        bp_cnt++;
        case (bp_mode)
            0: fready = 1'b1;
            1: fready = ($urandom % 3) != 0;
            default: fready = (bp_cnt % 7) == 0;
        endcase
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Reference model, compared every cycle
    always @(negedge clk) if (rst_n) begin
        if (rd_en) begin
            chk(int'({rd_side, rd_way, rd_idx}) == exp_rd, "R3 read order",
                {rd_side, rd_way, rd_idx}, exp_rd);
            chk(!fvalid, "R7 read while pending", fvalid, 0);
            exp_rd++;
        end
        if (fvalid) begin
            if (prev_v && !prev_r) chk(faddr == prev_a, "R7 held address", faddr, prev_a);
            if (fready) begin
                if (expq.size() == 0) chk(0, "R10 unexpected flush", faddr, 0);
                else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    chk(faddr == e, "R4/R5/R10 flush address", faddr, e);
                end
            end
        end
        if (done) begin
            chk(expq.size() == 0, "R9 flushes outstanding at done", expq.size(), 0);
            chk(exp_rd == N, "R9 reads before done", exp_rd, N);
            chk(!prev_done, "R9 done width", prev_done, 0);
        end
        prev_v = fvalid; prev_r = fready; prev_a = faddr; prev_done = done;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] mk_hi(input logic [7:0] tag);
        mk_hi = {19'($urandom), 5'($urandom), tag};
    endfunction

    task automatic build_queue(input logic [15:0] p);
        expq.delete();
        for (int k = 0; k < N; k++)
            if (mem_lo[k][3] && !mem_lo[k][4] && mem_hi[k][7:0] == p[7:0])
                expq.push_back({mem_hi[k][31:13], 13'd0});
    endtask

    task automatic run_scan(input logic [15:0] p, input bit intrude, output int n);
        build_queue(p);
        exp_rd = 0;
        @(posedge clk); #1 start = 1'b1; pid = p;
        n = 0;
        forever begin
            @(posedge clk); n++; #1 start = 1'b0;
            if (intrude && n == 20) begin start = 1'b1; pid = p ^ 16'h00FF; end
            @(negedge clk);
            if (done) break;
        end
        @(negedge clk);
        chk(!busy, "R9 idle after done", busy, 0);
        chk(expq.size() == 0, "R10 all flushes seen", expq.size(), 0);
    endtask

    initial begin
        int n;
        fready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !rd_en && !fvalid && !done, "R1 reset state",
            {busy, rd_en, fvalid, done}, 0);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!busy && !rd_en && !fvalid && !done, "R1 stays idle",
            {busy, rd_en, fvalid, done}, 0);

        // No entry matches: pace check
        for (int k = 0; k < N; k++) begin
            mem_hi[k] = mk_hi(8'h11); mem_lo[k] = 32'h8;
        end
        run_scan(16'h0022, 0, n);
        chk(n == 130, "R6 walk length without matches", n, 130);

        // Mixed content; upper tag bits set on the request
        for (int k = 0; k < N; k++) begin
            logic [7:0] t;
            case ($urandom % 4)
                0: t = 8'h5C; 1: t = 8'h5D; 2: t = 8'hA5; default: t = 8'h5C;
            endcase
            mem_hi[k] = mk_hi(t);
            mem_lo[k] = {27'($urandom), 2'($urandom % 4), 3'($urandom)};
        end
        mem_hi[5]  = {19'h1234, 5'h0, 8'hA5}; mem_lo[5] = 32'h8;   // upper byte of request only
        mem_hi[9]  = {19'h0ABC, 5'h0, 8'h5C}; mem_lo[9] = 32'h18;  // global
        mem_hi[10] = {19'h0ABD, 5'h0, 8'h5C}; mem_lo[10] = 32'h0;  // invalid
        mem_hi[11] = {19'h7FFFF, 5'h1F, 8'h5C}; mem_lo[11] = 32'hFFFFFFE8; // R5 low bits cleared
        run_scan(16'hA55C, 0, n);   // R2 R4 R5

        // Same with random backpressure
        bp_mode = 1;
        run_scan(16'h115D, 0, n);   // R7 R10

        // First, consecutive and last entries match; long stalls
        for (int k = 0; k < N; k++) begin
            mem_hi[k] = mk_hi(8'h33); mem_lo[k] = 32'h8;
        end
        for (int k = 0; k < N; k++)
            if (k == 0 || k == 1 || k == 2 || k == 64 || k == N - 1)
                mem_hi[k] = mk_hi(8'h77);
        bp_mode = 2;
        run_scan(16'h0077, 0, n);   // R3 R7 R9 R10

        // Start while busy with a different tag
        bp_mode = 0;
        run_scan(16'h0033, 1, n);   // R8

        repeat (5) @(negedge clk);
        chk(!busy && !rd_en && !fvalid, "R1 quiet after runs", {busy, rd_en, fvalid}, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule